// File: doc/BRIEF.md
# Line-Aliasing Outstanding Request Tracker

The tracker sits between a core and its first-level cache controller. It admits memory requests and files each one in one of two small fully associative tables. Loads go to a read table and every store-like or atomic request goes to a write table. Both tables are keyed by cache-line address. Each request gets one registered status back in the following cycle. An admitted request is also forwarded, in the same cycle as its status, to a downstream queue together with a coarser secondary request type.

Completions come back as a line address plus a read/write selector. A completion frees the matching entry and returns the stored request ID, any speculative loads that were merged into the entry, and the number of cycles the entry was held. Completions of locked read-modify-write requests also drive a single line lock. While that lock is held, every other request to the locked line is refused.

Top module: `line_req_tracker`

## Requirements
- R1: After a synchronous reset, `rsp_valid`, `ds_valid`, `done_valid` and `err_flag` are 0, and both tables are empty.
- R2: A request's line is `req_addr[ADDR_W-1:OFFSET_W]`. All table matching and locking use only the line, so two byte addresses that differ only in their offset bits alias.
- R3: When the outstanding count has reached `MAX_OUT`, any request gets status 3 (full). The tables are left unchanged.
- R4: `req_kind` encodes 0 load, 1 instruction fetch, 2 speculative load, 3 store, 4 RMW read, 5 load-linked, 6 store-conditional, 7 locked RMW read, 8 locked RMW write and 9 flush. Kinds 3 to 9 form the store class. A store-class request gets status 2 (aliased) when either table holds its line. Otherwise it takes a write entry and gets status 0 (issued).
- R5: A load-class request (kinds 0 to 2) is aliased when the write table holds its line. It is also aliased when the read table holds its line, except in the case covered by R6. Otherwise it takes a read entry and is issued.
- R6: A speculative load whose line is held by a read entry of kind 2 gets status 1 (merged, counted as issued). Its ID is added to that entry's dependent mask. No entry and no downstream request are created.
- R7: While the lock is held for a line, any request to that line other than kind 8 is aliased, unless R3 applies first.
- R8: A write completion of a kind-7 entry locks that entry's line. A write completion of a kind-8 entry releases the lock.
- R9: The outstanding count always equals the number of valid read entries plus the number of valid write entries. It never exceeds `MAX_OUT`.
- R10: An admissible request whose table has no free entry gets status 3, even when the total count is below `MAX_OUT`.
- R11: An issued request appears on `ds_*` in the same cycle as its status, with the byte address, the ID and a secondary type. The mapping to secondary type is: load→0, fetch→1, speculative→2, store, RMW read and locked RMW→3, load-linked and store-conditional→4, flush→5.
- R12: A matching completion raises `done_valid` in the next cycle. It returns the stored ID, the dependent mask (bit n set for merged ID n), and the latency, which is the number of clock edges from admission to completion.
- R13: A completion that matches no valid entry in its selected table sets `err_flag`, which stays 1 until reset. It does not raise `done_valid`.
- R14: A request whose line equals the line of a completion in the same cycle is aliased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_kind | input | 4 | Request kind (R4 encoding) |
| req_id | input | ID_W | Requester tag |
| cpl_valid | input | 1 | Completion this cycle |
| cpl_line | input | ADDR_W-OFFSET_W | Completed line address |
| cpl_is_write | input | 1 | 1 selects the write table, 0 the read table |
| rsp_valid | output | 1 | Status valid |
| rsp_status | output | 2 | 0 issued, 1 merged, 2 aliased, 3 full |
| rsp_id | output | ID_W | Tag of the answered request |
| ds_valid | output | 1 | Downstream request valid |
| ds_addr | output | ADDR_W | Forwarded byte address |
| ds_type | output | 3 | Secondary type (R11) |
| ds_id | output | ID_W | Forwarded tag |
| done_valid | output | 1 | Completion result valid |
| done_id | output | ID_W | Stored tag of the freed entry |
| done_deps | output | 2**ID_W | Merged dependent tags |
| done_latency | output | CYC_W | Cycles the entry was held |
| err_flag | output | 1 | Sticky unmatched-completion flag |

## Verification
A stale or lost valid bit in either table shows at the ports on the very next request to that line. The request comes back issued where aliased was due, or the reverse. A drifting outstanding count shows as a premature or missing full status as soon as the tables near capacity. The sweep crosses every pair of request kinds on one line, and then drains each entry. A corrupted ID, dependent mask, lock bit or issue cycle therefore appears one cycle after the completion that reads it.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [3:0] {
    K_LOAD = 4'd0, K_IFETCH = 4'd1, K_SPEC = 4'd2, K_STORE = 4'd3,
    K_RMW_RD = 4'd4, K_LL = 4'd5, K_SC = 4'd6, K_LOCK_RD = 4'd7,
    K_LOCK_WR = 4'd8, K_FLUSH = 4'd9
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0, ST_MERGED = 2'd1, ST_ALIASED = 2'd2, ST_FULL = 2'd3
  } rsp_status_e;

  typedef enum logic [2:0] {
    DS_LOAD = 3'd0, DS_IFETCH = 3'd1, DS_SPEC = 3'd2,
    DS_STORE = 3'd3, DS_ATOMIC = 3'd4, DS_FLUSH = 3'd5
  } ds_type_e;
endpackage

// File: rtl/lrt_classify.sv
module lrt_classify
  import lrt_pkg::*;
(
  input  logic [3:0] kind,
  output logic       is_load,
  output logic       is_spec,
  output logic       is_lock_wr,
  output logic [2:0] ds_type
);
  always_comb begin
    is_load    = (kind <= 4'd2);
    is_spec    = (kind == K_SPEC);
    is_lock_wr = (kind == K_LOCK_WR);
    case (kind)
      K_LOAD:       ds_type = DS_LOAD;
      K_IFETCH:     ds_type = DS_IFETCH;
      K_SPEC:       ds_type = DS_SPEC;
      K_LL, K_SC:   ds_type = DS_ATOMIC;
      K_FLUSH:      ds_type = DS_FLUSH;
      default:      ds_type = DS_STORE;
    endcase
  end
endmodule

// File: rtl/lrt_cam.sv
module lrt_cam #(
  parameter int N      = 4,
  parameter int LINE_W = 12,
  parameter int ID_W   = 4,
  parameter int CYC_W  = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int DEP_W = 1 << ID_W,
  localparam int USE_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic [3:0]        look_kind,
  output logic              free_ok,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [ID_W-1:0]   ins_id,
  input  logic [3:0]        ins_kind,
  input  logic [CYC_W-1:0]  ins_cyc,
  input  logic              merge_en,
  input  logic [ID_W-1:0]   merge_id,
  input  logic              cpl_en,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              cpl_hit,
  output logic [ID_W-1:0]   cpl_id,
  output logic [3:0]        cpl_kind,
  output logic [DEP_W-1:0]  cpl_deps,
  output logic [CYC_W-1:0]  cpl_cyc,
  output logic [USE_W-1:0]  used
);
  logic [N-1:0]      vld;
  logic [LINE_W-1:0] line_q [N];
  logic [ID_W-1:0]   id_q   [N];
  logic [3:0]        kind_q [N];
  logic [DEP_W-1:0]  deps_q [N];
  logic [CYC_W-1:0]  cyc_q  [N];
  logic [N-1:0]      look_m, cpl_m;
  logic [IDX_W-1:0]  look_idx, free_idx, cpl_idx;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign look_m[g] = vld[g] && (line_q[g] == look_line);
    assign cpl_m[g]  = vld[g] && (line_q[g] == cpl_line);
  end

  always_comb begin
    look_idx = '0;
    free_idx = '0;
    cpl_idx  = '0;
    used     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (look_m[i]) look_idx = IDX_W'(i);
      if (!vld[i])   free_idx = IDX_W'(i);
      if (cpl_m[i])  cpl_idx  = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) used = used + USE_W'(vld[i]);
  end

  assign look_hit  = |look_m;
  assign look_kind = kind_q[look_idx];
  assign free_ok   = ~&vld;
  assign cpl_hit   = cpl_en && (|cpl_m);
  assign cpl_id    = id_q[cpl_idx];
  assign cpl_kind  = kind_q[cpl_idx];
  assign cpl_deps  = deps_q[cpl_idx];
  assign cpl_cyc   = cyc_q[cpl_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (cpl_hit)          vld[cpl_idx]  <= 1'b0;
      if (ins_en && free_ok) vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && free_ok) begin
      line_q[free_idx] <= ins_line;
      id_q[free_idx]   <= ins_id;
      kind_q[free_idx] <= ins_kind;
      deps_q[free_idx] <= '0;
      cyc_q[free_idx]  <= ins_cyc;
    end
    if (merge_en && look_hit) deps_q[look_idx][merge_id] <= 1'b1;
  end

  // R4
  ins_room_chk: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> free_ok);
  // R5
  line_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cpl_m));
endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
  import lrt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 4,
  parameter int RD_N     = 4,
  parameter int WR_N     = 4,
  parameter int MAX_OUT  = 6,
  parameter int ID_W     = 4,
  parameter int CYC_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [3:0]                 req_kind,
  input  logic [ID_W-1:0]            req_id,
  input  logic                       cpl_valid,
  input  logic [ADDR_W-OFFSET_W-1:0] cpl_line,
  input  logic                       cpl_is_write,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_status,
  output logic [ID_W-1:0]            rsp_id,
  output logic                       ds_valid,
  output logic [ADDR_W-1:0]          ds_addr,
  output logic [2:0]                 ds_type,
  output logic [ID_W-1:0]            ds_id,
  output logic                       done_valid,
  output logic [ID_W-1:0]            done_id,
  output logic [(2**ID_W)-1:0]       done_deps,
  output logic [CYC_W-1:0]           done_latency,
  output logic                       err_flag
);
  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam int DEP_W  = 1 << ID_W;
  localparam int CNT_W  = $clog2(MAX_OUT + 1);

  logic [LINE_W-1:0] req_line, lock_line;
  logic              lock_v;
  logic [CNT_W-1:0]  cnt_q;
  logic [CYC_W-1:0]  now_q;
  logic              is_load, is_spec, is_lock_wr;
  logic [2:0]        sec_type;

  logic rd_hit, wr_hit, rd_free, wr_free, rd_ins, wr_ins, do_merge;
  logic [3:0] rd_kind, wr_kind_unused;
  logic rd_chit, wr_chit;
  logic [ID_W-1:0]  rd_cid, wr_cid;
  logic [3:0]       rd_ckind, wr_ckind;
  logic [DEP_W-1:0] rd_cdeps, wr_cdeps;
  logic [CYC_W-1:0] rd_ccyc, wr_ccyc;
  logic [$clog2(RD_N+1)-1:0] rd_used;
  logic [$clog2(WR_N+1)-1:0] wr_used;
  rsp_status_e dec;

  assign req_line = req_addr[ADDR_W-1:OFFSET_W];

  lrt_classify u_cls (
    .kind(req_kind), .is_load(is_load), .is_spec(is_spec),
    .is_lock_wr(is_lock_wr), .ds_type(sec_type)
  );

  lrt_cam #(.N(RD_N), .LINE_W(LINE_W), .ID_W(ID_W), .CYC_W(CYC_W)) u_rd (
    .clk, .rst, .look_line(req_line), .look_hit(rd_hit), .look_kind(rd_kind),
    .free_ok(rd_free), .ins_en(rd_ins), .ins_line(req_line), .ins_id(req_id),
    .ins_kind(req_kind), .ins_cyc(now_q), .merge_en(do_merge), .merge_id(req_id),
    .cpl_en(cpl_valid && !cpl_is_write), .cpl_line(cpl_line), .cpl_hit(rd_chit),
    .cpl_id(rd_cid), .cpl_kind(rd_ckind), .cpl_deps(rd_cdeps), .cpl_cyc(rd_ccyc),
    .used(rd_used)
  );

  lrt_cam #(.N(WR_N), .LINE_W(LINE_W), .ID_W(ID_W), .CYC_W(CYC_W)) u_wr (
    .clk, .rst, .look_line(req_line), .look_hit(wr_hit), .look_kind(wr_kind_unused),
    .free_ok(wr_free), .ins_en(wr_ins), .ins_line(req_line), .ins_id(req_id),
    .ins_kind(req_kind), .ins_cyc(now_q), .merge_en(1'b0), .merge_id(req_id),
    .cpl_en(cpl_valid && cpl_is_write), .cpl_line(cpl_line), .cpl_hit(wr_chit),
    .cpl_id(wr_cid), .cpl_kind(wr_ckind), .cpl_deps(wr_cdeps), .cpl_cyc(wr_ccyc),
    .used(wr_used)
  );

  // admission decision, priority: full, lock, same-cycle completion, tables
  always_comb begin
    dec      = ST_ALIASED;
    rd_ins   = 1'b0;
    wr_ins   = 1'b0;
    do_merge = 1'b0;
    if (cnt_q >= CNT_W'(MAX_OUT)) begin
      dec = ST_FULL;
    end else if (lock_v && lock_line == req_line && !is_lock_wr) begin
      dec = ST_ALIASED;
    end else if (cpl_valid && cpl_line == req_line) begin
      dec = ST_ALIASED;
    end else if (!is_load) begin
      if (rd_hit || wr_hit) dec = ST_ALIASED;
      else if (!wr_free)    dec = ST_FULL;
      else begin
        dec    = ST_ISSUED;
        wr_ins = req_valid;
      end
    end else begin
      if (wr_hit) dec = ST_ALIASED;
      else if (rd_hit) begin
        if (is_spec && rd_kind == K_SPEC) begin
          dec      = ST_MERGED;
          do_merge = req_valid;
        end else dec = ST_ALIASED;
      end else if (!rd_free) dec = ST_FULL;
      else begin
        dec    = ST_ISSUED;
        rd_ins = req_valid;
      end
    end
  end

  logic cpl_any_hit;
  assign cpl_any_hit = rd_chit || wr_chit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      now_q      <= '0;
      lock_v     <= 1'b0;
      lock_line  <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_id     <= '0;
      ds_valid   <= 1'b0;
      ds_addr    <= '0;
      ds_type    <= '0;
      ds_id      <= '0;
      done_valid <= 1'b0;
      done_id    <= '0;
      done_deps  <= '0;
      done_latency <= '0;
      err_flag   <= 1'b0;
    end else begin
      now_q      <= now_q + 1'b1;
      cnt_q      <= cnt_q + CNT_W'(rd_ins || wr_ins) - CNT_W'(cpl_any_hit);
      rsp_valid  <= req_valid;
      rsp_status <= dec;
      rsp_id     <= req_id;
      ds_valid   <= rd_ins || wr_ins;
      ds_addr    <= req_addr;
      ds_type    <= sec_type;
      ds_id      <= req_id;
      done_valid <= cpl_any_hit;
      if (rd_chit) begin
        done_id      <= rd_cid;
        done_deps    <= rd_cdeps;
        done_latency <= now_q - rd_ccyc;
      end else if (wr_chit) begin
        done_id      <= wr_cid;
        done_deps    <= wr_cdeps;
        done_latency <= now_q - wr_ccyc;
        if (wr_ckind == K_LOCK_RD) begin
          lock_v    <= 1'b1;
          lock_line <= cpl_line;
        end else if (wr_ckind == K_LOCK_WR) begin
          lock_v <= 1'b0;
        end
      end
      if (cpl_valid && !cpl_any_hit) err_flag <= 1'b1;
    end
  end

  // R9
  count_sum_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) == int'(rd_used) + int'(wr_used));
  // R9
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= MAX_OUT);
  // R3
  full_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cnt_q >= CNT_W'(MAX_OUT)) |=> (rsp_status == 2'(ST_FULL)));
  // R7
  lock_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lock_v && lock_line == req_line && req_kind != 4'(K_LOCK_WR))
      |=> (rsp_status == 2'(ST_ALIASED) || rsp_status == 2'(ST_FULL)));
  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R6
  merge_no_ds_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'(ST_MERGED)) |-> !ds_valid);
endmodule

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_kind = '0;
  logic [3:0]  req_id = '0;
  logic cpl_valid = 1'b0;
  logic [11:0] cpl_line = '0;
  logic cpl_is_write = 1'b0;
  logic rsp_valid, ds_valid, done_valid, err_flag;
  logic [1:0] rsp_status;
  logic [3:0] rsp_id, ds_id, done_id;
  logic [15:0] ds_addr, done_deps, done_latency;
  logic [2:0] ds_type;

  line_req_tracker u_line_req_tracker (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, bcyc = 0, t_req = 0;
  bit finished = 1'b0;
  always @(posedge clk) bcyc <= bcyc + 1;

  int g_st, g_ds, g_dst, g_dsid, g_done, g_did, g_deps, g_lat;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cap_rsp();
    g_st = rsp_status; g_ds = ds_valid; g_dst = ds_type; g_dsid = ds_id;
    g_done = done_valid; g_did = done_id; g_deps = done_deps; g_lat = done_latency;
  endtask

  task automatic do_req(input int line, input int off, input int k, input int id);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'((line << 4) | off);
    req_kind = 4'(k); req_id = 4'(id);
    @(posedge clk); #1;
    cap_rsp(); t_req = bcyc;
    req_valid = 1'b0;
  endtask

  task automatic do_cpl(input int line, input bit wr);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_line = 12'(line); cpl_is_write = wr;
    @(posedge clk); #1;
    cap_rsp();
    cpl_valid = 1'b0;
  endtask

  function automatic bit is_ld(input int k); return k <= 2; endfunction

  function automatic int exp_ds(input int k);
    case (k)
      0: return 0; 1: return 1; 2: return 2;
      5, 6: return 4; 9: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic int exp_pair(input int k1, input int k2);
    if (!is_ld(k2)) return 2;
    if (!is_ld(k1)) return 2;
    if (k1 == 2 && k2 == 2) return 1;
    return 2;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 ds_valid", ds_valid, 0);
    check("R1 done_valid", done_valid, 0);
    check("R1 err_flag", err_flag, 0);
    @(negedge clk); rst = 1'b0;

    // pair sweep on one line, offsets differ (R2, R4, R5, R6, R11, R12)
    for (int k1 = 0; k1 < 10; k1++) begin
      for (int k2 = 0; k2 < 10; k2++) begin
        int t0, es;
        do_req(16, 0, k1, 1);
        t0 = t_req;
        check("R4/R5 first issued", g_st, 0);
        check("R11 ds_valid", g_ds, 1);
        check("R11 ds_type", g_dst, exp_ds(k1));
        check("R11 ds_id", g_dsid, 1);
        do_req(16, 15 - k2, k2, 2);
        es = exp_pair(k1, k2);
        check("R2/R4/R5/R6 second status", g_st, es);
        check("R6 no downstream", g_ds, 0);
        do_cpl(16, !is_ld(k1));
        check("R12 done_valid", g_done, 1);
        check("R12 done_id", g_did, 1);
        check("R6 R12 deps", g_deps, (es == 1) ? (1 << 2) : 0);
        check("R12 latency", g_lat, bcyc - t0);
        if (k1 == 7) begin
          // R8 clear lock left by the locked read completion
          do_req(16, 0, 8, 3);
          check("R8 lock write issued", g_st, 0);
          do_cpl(16, 1'b1);
          check("R8 lock write done", g_did, 3);
        end
      end
    end

    // lock behaviour R7, R8
    do_req(40, 3, 7, 5);
    do_cpl(40, 1'b1);
    for (int k = 0; k < 10; k++) begin
      if (k != 8) begin
        do_req(40, k, k, 6);
        check("R7 locked line aliased", g_st, 2);
      end
    end
    do_req(41, 0, 0, 7);
    check("R7 other line issued", g_st, 0);
    do_cpl(41, 1'b0);
    do_req(40, 9, 8, 8);
    check("R7 lock write admitted", g_st, 0);
    do_cpl(40, 1'b1);
    do_req(40, 0, 0, 9);
    check("R8 unlocked load issued", g_st, 0);
    do_cpl(40, 1'b0);

    // table full R10 and total full R3, count R9
    for (int i = 0; i < 4; i++) begin
      do_req(100 + i, 0, 0, i);
      check("R10 fill read", g_st, 0);
    end
    do_req(110, 0, 1, 4);
    check("R10 read table full", g_st, 3);
    do_req(111, 0, 3, 5);
    check("R9 write issued", g_st, 0);
    do_req(112, 0, 5, 6);
    check("R9 write issued", g_st, 0);
    do_req(113, 0, 3, 7);
    check("R3 total full", g_st, 3);
    do_req(100, 0, 2, 8);
    check("R3 full before alias", g_st, 3);
    do_cpl(111, 1'b1);
    check("R9 free write done", g_did, 5);
    do_req(113, 0, 3, 7);
    check("R9 slot reusable", g_st, 0);
    do_cpl(113, 1'b1);
    do_cpl(112, 1'b1);
    for (int i = 0; i < 4; i++) begin
      do_cpl(100 + i, 1'b0);
      check("R12 drain id", g_did, i);
    end
    do_req(113, 0, 3, 7);
    check("R3 tables unchanged", g_st, 0);
    do_cpl(113, 1'b1);

    // same-cycle completion on the same line R14
    do_req(200, 0, 0, 10);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_line = 12'd200; cpl_is_write = 1'b0;
    req_valid = 1'b1; req_addr = 16'(200 << 4); req_kind = 4'd0; req_id = 4'd11;
    @(posedge clk); #1;
    cap_rsp();
    cpl_valid = 1'b0; req_valid = 1'b0;
    check("R14 same-cycle alias", g_st, 2);
    check("R14 completion done", g_did, 10);

    // unmatched completion R13
    check("R13 flag clear", err_flag, 0);
    do_cpl(300, 1'b0);
    check("R13 no done", g_done, 0);
    check("R13 flag set", err_flag, 1);
    repeat (3) @(posedge clk);
    #1;
    check("R13 flag sticky", err_flag, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule